// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor that completes one instruction on every clock edge. Each cycle, it does the following:

- fetches a word from a local instruction store, addressed by the program counter;
- decodes the six-bit operation code in bits 31:26;
- reads two operands from a 32-entry register file;
- runs the ALU;
- optionally reads or writes a local data store;
- writes back a result and computes the next program counter.

The operation code alone selects the operation. Each register-register operation has its own code, so bits 5:0 of an instruction have no effect.

A program is loaded through a dedicated write port into the instruction store while reset is held. Reset is then released and execution starts at address 0. Observation outputs show the current program counter and the register-file write port: enable, index and data. A test environment can follow every architectural result without reaching into the core.

Top module: `scpu_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0. While reset is high, no register-file or data-store write takes place, and the debug write enable is 0.
- R2: Opcodes 1 (add), 2 (sub), 3 (and) and 4 (or) combine the registers at bits 25:21 and 20:16 and write the result to the register at bits 15:11. Bits 10:0 are ignored.
- R3: slt (opcode 5) and slti (opcode 13) write 1 when the first operand is less than the second in a signed comparison, and write 0 otherwise.
- R4: The immediate operations write their result to the register at bits 20:16. These are addi (10), andi (11), ori (12) and slti (13). addi and slti sign-extend bits 15:0; andi and ori zero-extend them.
- R5: lw (6) and sw (7) address the data store with the register at bits 25:21 plus the sign-extended offset. lw writes the loaded word to the register at bits 20:16. sw stores that register and writes no register.
- R6: beq (8) branches when the two registers are equal and bne (9) branches when they differ. A taken branch goes to PC+4 plus the sign-extended offset times 4. A branch not taken goes to PC+4. Neither writes a register.
- R7: j (14) goes to {PC+4[31:28], bits 25:0, 2'b00}.
- R8: Opcode 0 and opcodes 15 to 63 write neither the register file nor the data store, and advance the PC by 4.
- R9: Register 0 always reads as zero. A write to it is shown on the debug port but does not change the register.
- R10: While the instruction-store write enable is high, the data word is stored at the given word address.
- R11: The debug outputs show the current PC and the register write enable, index and data for the instruction being executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imemWe | input | 1 | Instruction store load enable |
| imemAddr | input | IAW | Instruction store word address |
| imemData | input | 32 | Instruction word to load |
| dbgPc | output | 32 | Current program counter |
| dbgRegWe | output | 1 | Register-file write enable this cycle |
| dbgRegAddr | output | 5 | Register-file write index |
| dbgRegData | output | 32 | Register-file write data |

## Verification
Register-register operations are tried with one positive and one negative operand. This lets sub differ from add, and lets slt differ from an unsigned comparison. Nonzero filler in bits 10:0 shows that the function field is never decoded. Immediates with bit 15 set separate sign extension from zero extension. A load with a negative offset from a base register checks the address arithmetic. A trace of program-counter values through taken and untaken branches of both kinds, a jump and a backward self-branch separates each next-PC source. Unknown opcodes are placed between a store and a reload, with fields that look like a store of a different value, to show that the data store is left alone.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

  typedef enum logic [5:0] {
    OP_NOP  = 6'd0,
    OP_ADD  = 6'd1,
    OP_SUB  = 6'd2,
    OP_AND  = 6'd3,
    OP_OR   = 6'd4,
    OP_SLT  = 6'd5,
    OP_LW   = 6'd6,
    OP_SW   = 6'd7,
    OP_BEQ  = 6'd8,
    OP_BNE  = 6'd9,
    OP_ADDI = 6'd10,
    OP_ANDI = 6'd11,
    OP_ORI  = 6'd12,
    OP_SLTI = 6'd13,
    OP_J    = 6'd14
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    regWrite;
    logic    regDstRd;
    logic    aluSrcImm;
    logic    zeroExt;
    logic    memWrite;
    logic    memToReg;
    logic    branchEq;
    logic    branchNe;
    logic    jump;
    alu_op_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/scpu_control.sv
module scpu_control
  import scpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opcode,
  output ctrl_t       ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    case (opcode)
      OP_ADD:  begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_ADD; end
      OP_SUB:  begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_SUB; end
      OP_AND:  begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_AND; end
      OP_OR:   begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_OR;  end
      OP_SLT:  begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_SLT; end
      OP_LW:   begin ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.memToReg = 1'b1; end
      OP_SW:   begin ctrl.memWrite = 1'b1; ctrl.aluSrcImm = 1'b1; end
      OP_BEQ:  begin ctrl.branchEq = 1'b1; end
      OP_BNE:  begin ctrl.branchNe = 1'b1; end
      OP_ADDI: begin ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.aluOp = ALU_ADD; end
      OP_ANDI: begin ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.zeroExt = 1'b1; ctrl.aluOp = ALU_AND; end
      OP_ORI:  begin ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.zeroExt = 1'b1; ctrl.aluOp = ALU_OR; end
      OP_SLTI: begin ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.aluOp = ALU_SLT; end
      OP_J:    begin ctrl.jump = 1'b1; end
      default: ;
    endcase
  end

  // R8: no-op and unknown codes must not touch any storage
  p_nop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (opcode == 6'd0 || opcode > 6'd14) |-> (!ctrl.regWrite && !ctrl.memWrite && !ctrl.jump
                                             && !ctrl.branchEq && !ctrl.branchNe));

  // R6: a branch code never requests a write
  p_branch_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branchEq || ctrl.branchNe) |-> (!ctrl.regWrite && !ctrl.memWrite));

  // at most one next-PC source selected
  p_one_flow_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.jump, ctrl.branchEq, ctrl.branchNe}));

endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y
);

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [RAW-1:0]   wAddr,
  input  logic [XLEN-1:0]  wData,
  input  logic [RAW-1:0]   rAddrA,
  input  logic [RAW-1:0]   rAddrB,
  output logic [XLEN-1:0]  rDataA,
  output logic [XLEN-1:0]  rDataB
);

  logic [XLEN-1:0] regs [1:NREGS-1];

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && wAddr == RAW'(g)) regs[g] <= wData;
    end
  end

  assign rDataA = (rAddrA == '0) ? '0 : regs[rAddrA];
  assign rDataB = (rAddrB == '0) ? '0 : regs[rAddrB];

  // R9: register 0 reads as zero on both ports
  always_comb begin
    if (rAddrA == '0) p_zero_reg_a_r9: assert (rDataA == '0);
    if (rAddrB == '0) p_zero_reg_b_r9: assert (rDataB == '0);
  end

endmodule

// File: rtl/scpu_datapath.sv
module scpu_datapath
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  output logic [5:0]      opcode,
  input  logic            imemWe,
  input  logic [IAW-1:0]  imemAddr,
  input  logic [31:0]     imemData,
  output logic [31:0]     dbgPc,
  output logic            dbgRegWe,
  output logic [4:0]      dbgRegAddr,
  output logic [31:0]     dbgRegData
);

  logic [31:0] pc, pcPlus4, nextPc, instr;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] imm32, rsData, rtData, aluB, aluRes, loadData, wbData;
  logic [31:0] brTarget, jTarget;
  logic [4:0]  rsIdx, rtIdx, rdIdx, wAddr;
  logic        regWe, memWe, takeBranch, unusedBits;

  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemData;
  end

  assign instr  = imem[pc[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign unusedBits = ^{instr[10:0], aluRes[1:0], aluRes[31:DAW+2], pc[1:0]};

  assign imm32 = ctrl.zeroExt ? {16'b0, instr[15:0]} : {{16{instr[15]}}, instr[15:0]};

  scpu_regfile #(.XLEN(32), .NREGS(32)) u_regs (
    .clk    (clk),
    .we     (regWe),
    .wAddr  (wAddr),
    .wData  (wbData),
    .rAddrA (rsIdx),
    .rAddrB (rtIdx),
    .rDataA (rsData),
    .rDataB (rtData)
  );

  assign aluB = ctrl.aluSrcImm ? imm32 : rtData;

  scpu_alu #(.XLEN(32)) u_alu (
    .op (ctrl.aluOp),
    .a  (rsData),
    .b  (aluB),
    .y  (aluRes)
  );

  assign memWe    = ctrl.memWrite && !rst;
  assign loadData = dmem[aluRes[DAW+1:2]];

  always_ff @(posedge clk) begin
    if (memWe) dmem[aluRes[DAW+1:2]] <= rtData;
  end

  assign wbData = ctrl.memToReg ? loadData : aluRes;
  assign wAddr  = ctrl.regDstRd ? rdIdx : rtIdx;
  assign regWe  = ctrl.regWrite && !rst;

  assign pcPlus4    = pc + 32'd4;
  assign brTarget   = pcPlus4 + {imm32[29:0], 2'b00};
  assign jTarget    = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign takeBranch = (ctrl.branchEq && rsData == rtData) || (ctrl.branchNe && rsData != rtData);

  always_comb begin
    if (ctrl.jump)      nextPc = jTarget;
    else if (takeBranch) nextPc = brTarget;
    else                nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nextPc;
  end

  assign dbgPc      = pc;
  assign dbgRegWe   = regWe;
  assign dbgRegAddr = wAddr;
  assign dbgRegData = wbData;

  // R1: reset returns the PC to zero on the following edge
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc == 32'd0));

  // R1: no storage write while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk) rst |-> (!regWe && !memWe));

  // R8: without a flow-change strobe the PC advances by one word
  p_seq_pc_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !ctrl.branchEq && !ctrl.branchNe) |=> (pc == $past(pc) + 32'd4));

  // R5: a store never writes the register file
  p_store_no_reg_r5: assert property (@(posedge clk) disable iff (rst)
    memWe |-> !regWe);

  // R7: a jump keeps the top four bits of the incremented PC
  p_jump_region_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc[31:28] == $past(pcPlus4[31:28])));

endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imemWe,
  input  logic [IAW-1:0]  imemAddr,
  input  logic [31:0]     imemData,
  output logic [31:0]     dbgPc,
  output logic            dbgRegWe,
  output logic [4:0]      dbgRegAddr,
  output logic [31:0]     dbgRegData
);

  ctrl_t      ctrl;
  logic [5:0] opcode;

  scpu_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  scpu_datapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .opcode     (opcode),
    .imemWe     (imemWe),
    .imemAddr   (imemAddr),
    .imemData   (imemData),
    .dbgPc      (dbgPc),
    .dbgRegWe   (dbgRegWe),
    .dbgRegAddr (dbgRegAddr),
    .dbgRegData (dbgRegData)
  );

endmodule

// File: tb/scpu_core_test.sv
`timescale 1ns/1ps
module scpu_core_test;

  localparam int WORDS = 64;
  localparam int AW = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic imemWe = 1'b0;
  logic [AW-1:0] imemAddr = '0;
  logic [31:0] imemData = '0;
  logic [31:0] dbgPc, dbgRegData;
  logic dbgRegWe;
  logic [4:0] dbgRegAddr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [31:0] prog [WORDS];
  logic [31:0] pcTr [32];
  logic        weTr [32];
  logic [4:0]  waTr [32];
  logic [31:0] wdTr [32];

  always #2.5 clk = ~clk;

  scpu_core #(.IMEM_WORDS(WORDS), .DMEM_WORDS(WORDS)) uut (
    .clk(clk), .rst(rst), .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .dbgPc(dbgPc), .dbgRegWe(dbgRegWe), .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] rOp(int op, int rs, int rt, int rd, int junk);
    return {6'(op), 5'(rs), 5'(rt), 5'(rd), 11'(junk)};
  endfunction
  function automatic logic [31:0] iOp(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] jOp(int addr);
    return {6'd14, 26'(addr)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < WORDS; i++) prog[i] = 32'd0;
  endtask

  // hold reset, load the whole store through the write port (R10)
  task automatic loadProg();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < WORDS; i++) begin
      imemWe = 1'b1; imemAddr = AW'(i); imemData = prog[i];
      @(negedge clk);
    end
    imemWe = 1'b0;
    @(negedge clk);
  endtask

  // release reset at a falling edge and trace n instructions
  task automatic run(input int n);
    rst = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1;
      pcTr[i] = dbgPc; weTr[i] = dbgRegWe; waTr[i] = dbgRegAddr; wdTr[i] = dbgRegData;
      @(negedge clk);
    end
  endtask

  task automatic expWr(input int i, input int addr, input logic [31:0] data, input string req);
    chk(weTr[i] == 1'b1 && waTr[i] == 5'(addr) && wdTr[i] == data, req,
        {weTr[i], 26'(waTr[i]), 5'd0} ^ 32'd0 | 32'(wdTr[i] & 0), 32'd0);
    chk(wdTr[i] == data, req, wdTr[i], data);
  endtask

  task automatic expNoWr(input int i, input string req);
    chk(weTr[i] == 1'b0, req, 32'(weTr[i]), 32'd0);
  endtask

  task automatic testReset();
    clearProg();
    prog[0] = iOp(10, 0, 1, 7);
    loadProg();
    #1;
    chk(dbgPc == 32'd0, "R1 pc in reset", dbgPc, 32'd0);
    chk(dbgRegWe == 1'b0, "R1 no write in reset", 32'(dbgRegWe), 32'd0);
    run(3);
    chk(pcTr[2] == 32'd8, "R11 pc advance", pcTr[2], 32'd8);
    rst = 1'b1;
    @(negedge clk); #1;
    chk(dbgPc == 32'd0, "R1 mid-run reset", dbgPc, 32'd0);
  endtask

  task automatic testRegReg();
    clearProg();
    prog[0] = iOp(10, 0, 1, 5);
    prog[1] = iOp(10, 0, 2, 16'hFFFD);
    prog[2] = rOp(1, 1, 2, 3, 11'h2AA);
    prog[3] = rOp(2, 1, 2, 4, 11'h7FF);
    prog[4] = rOp(3, 1, 2, 5, 0);
    prog[5] = rOp(4, 1, 2, 6, 0);
    prog[6] = rOp(5, 2, 1, 7, 0);
    prog[7] = rOp(5, 1, 2, 8, 0);
    loadProg(); run(8);
    expWr(1, 2, 32'hFFFFFFFD, "R4 addi sign extend");
    expWr(2, 3, 32'd2, "R2 add to rd, funct ignored");
    expWr(3, 4, 32'd8, "R2 sub");
    expWr(4, 5, 32'd5, "R2 and");
    expWr(5, 6, 32'hFFFFFFFD, "R2 or");
    expWr(6, 7, 32'd1, "R3 slt signed true");
    expWr(7, 8, 32'd0, "R3 slt signed false");
  endtask

  task automatic testImm();
    clearProg();
    prog[0] = iOp(10, 0, 1, 16'hFFFF);
    prog[1] = iOp(11, 1, 2, 16'h8001);
    prog[2] = iOp(12, 0, 3, 16'h8000);
    prog[3] = iOp(13, 1, 4, 0);
    prog[4] = iOp(13, 0, 5, 16'hFFFF);
    loadProg(); run(5);
    expWr(0, 1, 32'hFFFFFFFF, "R4 addi to rt");
    expWr(1, 2, 32'h00008001, "R4 andi zero extend");
    expWr(2, 3, 32'h00008000, "R4 ori zero extend");
    expWr(3, 4, 32'd1, "R3 slti true");
    expWr(4, 5, 32'd0, "R3 slti false");
  endtask

  task automatic testMem();
    clearProg();
    prog[0] = iOp(10, 0, 1, 16'h77);
    prog[1] = iOp(7, 0, 1, 8);
    prog[2] = iOp(6, 0, 2, 8);
    prog[3] = iOp(10, 0, 3, 16);
    prog[4] = iOp(6, 3, 4, 16'hFFF8);
    loadProg(); run(5);
    expNoWr(1, "R5 sw writes no register");
    expWr(2, 2, 32'h77, "R5 lw reads stored word");
    expWr(4, 4, 32'h77, "R5 lw negative offset");
  endtask

  task automatic testNop();
    clearProg();
    prog[0] = iOp(10, 0, 1, 16'h11);
    prog[1] = iOp(10, 0, 3, 16'h22);
    prog[2] = iOp(7, 0, 1, 0);
    prog[3] = 32'd0;
    prog[4] = iOp(15, 0, 3, 0);
    prog[5] = iOp(63, 0, 3, 0);
    prog[6] = iOp(6, 0, 2, 0);
    prog[7] = rOp(1, 1, 1, 0, 0);
    prog[8] = rOp(1, 0, 0, 9, 0);
    loadProg(); run(9);
    expNoWr(3, "R8 opcode 0 quiet");
    expNoWr(4, "R8 opcode 15 quiet");
    expNoWr(5, "R8 opcode 63 quiet");
    chk(pcTr[5] == 32'd20 && pcTr[6] == 32'd24, "R8 pc plus 4", pcTr[6], 32'd24);
    expWr(6, 2, 32'h11, "R8 store unchanged by unknown op");
    expWr(7, 0, 32'h22, "R9 write to r0 shown");
    expWr(8, 9, 32'd0, "R9 r0 reads zero");
  endtask

  task automatic testFlow();
    logic [31:0] expPc [10];
    clearProg();
    prog[0]  = iOp(10, 0, 1, 3);
    prog[1]  = iOp(10, 0, 2, 3);
    prog[2]  = iOp(8, 1, 2, 2);
    prog[3]  = iOp(10, 0, 9, 1);
    prog[4]  = iOp(10, 0, 9, 1);
    prog[5]  = iOp(9, 1, 2, 5);
    prog[6]  = iOp(8, 1, 0, 5);
    prog[7]  = iOp(9, 1, 0, 1);
    prog[8]  = iOp(10, 0, 9, 1);
    prog[9]  = jOp(16);
    prog[16] = iOp(8, 0, 0, 16'hFFFF);
    expPc = '{0, 4, 8, 20, 24, 28, 36, 64, 64, 64};
    loadProg(); run(10);
    chk(pcTr[3] == expPc[3], "R6 beq taken", pcTr[3], expPc[3]);
    chk(pcTr[4] == expPc[4], "R6 bne not taken", pcTr[4], expPc[4]);
    chk(pcTr[5] == expPc[5], "R6 beq not taken", pcTr[5], expPc[5]);
    chk(pcTr[6] == expPc[6], "R6 bne taken", pcTr[6], expPc[6]);
    chk(pcTr[7] == expPc[7], "R7 jump target", pcTr[7], expPc[7]);
    chk(pcTr[9] == expPc[9], "R6 backward self branch", pcTr[9], expPc[9]);
    for (int i = 2; i < 10; i++) expNoWr(i, "R6 R7 flow writes nothing");
  endtask

  initial begin
    testReset();
    testRegReg();
    testImm();
    testMem();
    testNop();
    testFlow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule